// File: doc/BRIEF.md
# Preamble Plateau Frame Detector

This block watches a stream of complex baseband samples and signals the start of an OFDM frame. A training preamble repeats with a short period. Two lagged self-correlators turn that repetition into a flat-topped ridge in the correlation magnitude. The block differentiates the squared magnitude of the long correlator over a fixed lag. It then tracks the running maximum of that difference, and raises a one-cycle detect pulse once the maximum has stood unbeaten for a programmable number of samples and lies above a programmable floor.

On the detect cycle the block captures the complex sums of both correlators. A downstream frequency-offset estimator reads these sums: the long path gives a low-noise estimate and the short path resolves its ambiguity. After a detection the block ignores the stream until it is rearmed. Saturated converter samples are zeroed before they reach either correlator.

Top module: `plateau_frame_detector`

## Requirements
- R1: A sample accepted with `smp_clip` high enters both correlators as zero, in both the real and the imaginary part.
- R2: After sample x(n) is accepted, each correlator holds the sum over its last LEN accepted samples of x(m)·conj(x(m−LAG)). Samples from before reset count as zero. The long path uses LAG = LEN = 64 and the short path uses LAG = LEN = 16.
- R3: Every stage advances only on cycles with `smp_vld` high. Idle cycles change neither the correlation sums nor the detection timing, which counts accepted samples only.
- R4: When sample k is accepted, the peak tracker is fed D(k−1), where D(k) = Q(k−1) − Q(k−17) and Q(k) = |Jlong(k−1)|². Terms with a negative index are zero.
- R5: While armed, each accepted sample compares the fed difference with the stored maximum, which is zero after reset. A strictly larger value replaces the maximum and clears the hold counter.
- R6: Otherwise the hold counter increments, saturating at `hold_len`. The step on which it reaches `hold_len` raises a detection only if the stored maximum exceeds `det_floor`, read as an unsigned value.
- R7: `frame_det` is high for exactly one cycle, the cycle after the accepting edge on which the detection is made.
- R8: On a detection, the four sum outputs load the correlator sums that include the sample accepted on that edge. At all other times they hold their value.
- R9: After a detection no further pulse occurs, whatever the input, until `rearm` is pulsed.
- R10: A `rearm` cycle clears the stored maximum and the hold counter and re-enables detection. It takes priority over a sample accepted in the same cycle, which still enters the correlators.
- R11: After reset `frame_det` is low, all sum outputs are zero and the detector is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe |
| smp_re | input | 8 | Sample real part, signed |
| smp_im | input | 8 | Sample imaginary part, signed |
| smp_clip | input | 1 | Sample is saturated; treat it as zero |
| rearm | input | 1 | Re-enable detection and clear the peak state |
| hold_len | input | 8 | Accepted samples without a new maximum needed before detection |
| det_floor | input | 46 | Minimum peak value for a detection, unsigned |
| frame_det | output | 1 | One-cycle frame detect pulse |
| fine_re | output | 23 | Captured long-path sum, real part |
| fine_im | output | 23 | Captured long-path sum, imaginary part |
| coarse_re | output | 21 | Captured short-path sum, real part |
| coarse_im | output | 21 | Captured short-path sum, imaginary part |

## Verification
The hardest state to reach from the ports is a second detection after a rearm. It needs a full preamble that has already disarmed the block and left a large maximum stored. A much weaker preamble then follows, and it can only fire if rearm truly cleared that maximum. The stimulus drives a strong burst to detection, replays a burst without rearm to confirm silence, then pulses rearm together with a valid sample and sends a low-amplitude burst under a lowered floor. Clipped samples and idle gaps inside bursts move the detection point relative to wall-clock cycles. The bench therefore follows the accepted-sample index through its own windowed sums rather than any cycle schedule.

// File: rtl/frd_pkg.sv
package frd_pkg;
  localparam int SMP_W_DEF    = 8;
  localparam int LONG_LAG_DEF = 64;
  localparam int LONG_LEN_DEF = 64;
  localparam int SHRT_LAG_DEF = 16;
  localparam int SHRT_LEN_DEF = 16;
  localparam int DIFF_LAG_DEF = 16;
  localparam int HOLD_W_DEF   = 8;
endpackage

// File: rtl/frd_xcorr.sv
// Lagged self-correlator: x(n)*conj(x(n-LAG)) summed over a sliding window of LEN.
module frd_xcorr #(
  parameter int DW  = 8,
  parameter int LAG = 64,
  parameter int LEN = 64,
  parameter int AW  = 2*DW + 1 + $clog2(LEN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vld,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic signed [AW-1:0] acc_re,
  output logic signed [AW-1:0] acc_im,
  output logic signed [AW-1:0] nxt_re,
  output logic signed [AW-1:0] nxt_im
);
  localparam int PW = 2*DW + 1;

  logic signed [DW-1:0] dly_re [LAG];
  logic signed [DW-1:0] dly_im [LAG];
  logic signed [PW-1:0] win_re [LEN];
  logic signed [PW-1:0] win_im [LEN];
  logic signed [PW-1:0] prod_re, prod_im;
  logic signed [AW-1:0] acc_re_q, acc_im_q, acc_re_d, acc_im_d;

  always_comb begin
    prod_re = PW'(in_re) * PW'(dly_re[LAG-1]) + PW'(in_im) * PW'(dly_im[LAG-1]);
    prod_im = PW'(in_im) * PW'(dly_re[LAG-1]) - PW'(in_re) * PW'(dly_im[LAG-1]);
    acc_re_d = acc_re_q;
    acc_im_d = acc_im_q;
    if (vld) begin
      acc_re_d = acc_re_q + AW'(prod_re) - AW'(win_re[LEN-1]);
      acc_im_d = acc_im_q + AW'(prod_im) - AW'(win_im[LEN-1]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAG; i++) begin
        dly_re[i] <= '0;
        dly_im[i] <= '0;
      end
      for (int i = 0; i < LEN; i++) begin
        win_re[i] <= '0;
        win_im[i] <= '0;
      end
      acc_re_q <= '0;
      acc_im_q <= '0;
    end else if (vld) begin
      dly_re[0] <= in_re;
      dly_im[0] <= in_im;
      for (int i = 1; i < LAG; i++) begin
        dly_re[i] <= dly_re[i-1];
        dly_im[i] <= dly_im[i-1];
      end
      win_re[0] <= prod_re;
      win_im[0] <= prod_im;
      for (int i = 1; i < LEN; i++) begin
        win_re[i] <= win_re[i-1];
        win_im[i] <= win_im[i-1];
      end
      acc_re_q <= acc_re_d;
      acc_im_q <= acc_im_d;
    end
  end

  assign acc_re = acc_re_q;
  assign acc_im = acc_im_q;
  assign nxt_re = acc_re_d;
  assign nxt_im = acc_im_d;

  // R3: an idle cycle leaves the window sum untouched
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> ($stable(acc_re_q) && $stable(acc_im_q)));
endmodule

// File: rtl/frd_plateau.sv
// Squared magnitude of the long correlation, then a lagged difference.
module frd_plateau #(
  parameter int JW  = 23,
  parameter int LAG = 16,
  parameter int QW  = 2*JW,
  parameter int DFW = QW + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  vld,
  input  logic signed [JW-1:0]  j_re,
  input  logic signed [JW-1:0]  j_im,
  output logic signed [DFW-1:0] diff
);
  logic signed [QW-1:0]  sq_re, sq_im;
  logic        [QW-1:0]  mag_d, mag_q;
  logic        [QW-1:0]  mdl [LAG];
  logic signed [DFW-1:0] diff_d, diff_q;

  always_comb begin
    sq_re  = QW'(j_re) * QW'(j_re);
    sq_im  = QW'(j_im) * QW'(j_im);
    mag_d  = $unsigned(sq_re + sq_im);
    diff_d = $signed({1'b0, mag_q}) - $signed({1'b0, mdl[LAG-1]});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_q  <= '0;
      diff_q <= '0;
      for (int i = 0; i < LAG; i++) mdl[i] <= '0;
    end else if (vld) begin
      mag_q  <= mag_d;
      diff_q <= diff_d;
      mdl[0] <= mag_q;
      for (int i = 1; i < LAG; i++) mdl[i] <= mdl[i-1];
    end
  end

  assign diff = diff_q;

  // R3: the difference only moves on accepted samples
  a_r3_diff_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> $stable(diff_q));
endmodule

// File: rtl/frd_peak.sv
// Running-maximum tracker with hold counter, floor test and arm state.
module frd_peak #(
  parameter int DW = 47,
  parameter int HW = 8,
  parameter int FW = DW - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vld,
  input  logic                 rearm,
  input  logic [HW-1:0]        hold,
  input  logic [FW-1:0]        floor_lvl,
  input  logic signed [DW-1:0] diff,
  output logic                 det_d,
  output logic                 det_q
);
  logic signed [DW-1:0] max_q, max_d;
  logic [HW-1:0]        cnt_q, cnt_d;
  logic                 armed_q, armed_d;

  always_comb begin
    max_d   = max_q;
    cnt_d   = cnt_q;
    armed_d = armed_q;
    det_d   = 1'b0;
    if (rearm) begin
      max_d   = '0;
      cnt_d   = '0;
      armed_d = 1'b1;
    end else if (vld && armed_q) begin
      if (diff > max_q) begin
        max_d = diff;
        cnt_d = '0;
      end else if (cnt_q < hold) begin
        cnt_d = cnt_q + 1'b1;
        if ((cnt_d == hold) && (max_q > $signed({1'b0, floor_lvl}))) begin
          det_d   = 1'b1;
          armed_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_q   <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b1;
      det_q   <= 1'b0;
    end else begin
      max_q   <= max_d;
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      det_q   <= det_d;
    end
  end

  // R7: the pulse never lasts two cycles
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    det_q |=> !det_q);
  // R9: disarmed and not rearmed means silent
  a_r9_quiet_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !rearm) |=> !det_q);
  // R6: a detection only follows a peak above the floor
  a_r6_above_floor: assert property (@(posedge clk) disable iff (!rst_n)
    det_q |-> (max_q > $signed({1'b0, $past(floor_lvl)})));
  // R10: rearm clears the peak state and arms
  a_r10_rearm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> (max_q == '0 && cnt_q == '0 && armed_q));
endmodule

// File: rtl/plateau_frame_detector.sv
module plateau_frame_detector
  import frd_pkg::*;
#(
  parameter int SMP_W    = SMP_W_DEF,
  parameter int LONG_LAG = LONG_LAG_DEF,
  parameter int LONG_LEN = LONG_LEN_DEF,
  parameter int SHRT_LAG = SHRT_LAG_DEF,
  parameter int SHRT_LEN = SHRT_LEN_DEF,
  parameter int DIFF_LAG = DIFF_LAG_DEF,
  parameter int HOLD_W   = HOLD_W_DEF,
  localparam int LAW     = 2*SMP_W + 1 + $clog2(LONG_LEN),
  localparam int SAW     = 2*SMP_W + 1 + $clog2(SHRT_LEN),
  localparam int QW      = 2*LAW,
  localparam int DFW     = QW + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_vld,
  input  logic signed [SMP_W-1:0] smp_re,
  input  logic signed [SMP_W-1:0] smp_im,
  input  logic                    smp_clip,
  input  logic                    rearm,
  input  logic [HOLD_W-1:0]       hold_len,
  input  logic [QW-1:0]           det_floor,
  output logic                    frame_det,
  output logic signed [LAW-1:0]   fine_re,
  output logic signed [LAW-1:0]   fine_im,
  output logic signed [SAW-1:0]   coarse_re,
  output logic signed [SAW-1:0]   coarse_im
);
  logic [1:0] rst_sync;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  logic signed [SMP_W-1:0] x_re, x_im;
  assign x_re = smp_clip ? '0 : smp_re;
  assign x_im = smp_clip ? '0 : smp_im;

  logic signed [LAW-1:0] l_re, l_im, l_nre, l_nim;
  logic signed [SAW-1:0] s_re, s_im, s_nre, s_nim;
  logic signed [DFW-1:0] diff;
  logic                  det_d, det_q;

  frd_xcorr #(.DW(SMP_W), .LAG(LONG_LAG), .LEN(LONG_LEN), .AW(LAW)) u_long (
    .clk(clk), .rst_n(rst_n_s), .vld(smp_vld), .in_re(x_re), .in_im(x_im),
    .acc_re(l_re), .acc_im(l_im), .nxt_re(l_nre), .nxt_im(l_nim));

  frd_xcorr #(.DW(SMP_W), .LAG(SHRT_LAG), .LEN(SHRT_LEN), .AW(SAW)) u_short (
    .clk(clk), .rst_n(rst_n_s), .vld(smp_vld), .in_re(x_re), .in_im(x_im),
    .acc_re(s_re), .acc_im(s_im), .nxt_re(s_nre), .nxt_im(s_nim));

  frd_plateau #(.JW(LAW), .LAG(DIFF_LAG), .QW(QW), .DFW(DFW)) u_plat (
    .clk(clk), .rst_n(rst_n_s), .vld(smp_vld), .j_re(l_re), .j_im(l_im),
    .diff(diff));

  frd_peak #(.DW(DFW), .HW(HOLD_W), .FW(QW)) u_peak (
    .clk(clk), .rst_n(rst_n_s), .vld(smp_vld), .rearm(rearm), .hold(hold_len),
    .floor_lvl(det_floor), .diff(diff), .det_d(det_d), .det_q(det_q));

  logic signed [LAW-1:0] cap_lre_q, cap_lim_q, cap_lre_d, cap_lim_d;
  logic signed [SAW-1:0] cap_sre_q, cap_sim_q, cap_sre_d, cap_sim_d;

  always_comb begin
    cap_lre_d = cap_lre_q;
    cap_lim_d = cap_lim_q;
    cap_sre_d = cap_sre_q;
    cap_sim_d = cap_sim_q;
    if (det_d) begin
      cap_lre_d = l_nre;
      cap_lim_d = l_nim;
      cap_sre_d = s_nre;
      cap_sim_d = s_nim;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cap_lre_q <= '0;
      cap_lim_q <= '0;
      cap_sre_q <= '0;
      cap_sim_q <= '0;
    end else begin
      cap_lre_q <= cap_lre_d;
      cap_lim_q <= cap_lim_d;
      cap_sre_q <= cap_sre_d;
      cap_sim_q <= cap_sim_d;
    end
  end

  assign frame_det = det_q;
  assign fine_re   = cap_lre_q;
  assign fine_im   = cap_lim_q;
  assign coarse_re = cap_sre_q;
  assign coarse_im = cap_sim_q;

  // R8: captured sums move only together with a detect pulse
  a_r8_capture_on_det: assert property (@(posedge clk) disable iff (!rst_n_s)
    !($stable(cap_lre_q) && $stable(cap_lim_q) && $stable(cap_sre_q) && $stable(cap_sim_q))
      |-> det_q);
endmodule

// File: tb/plateau_frame_detector_bench.sv
`timescale 1ns/1ps
module plateau_frame_detector_bench;
  localparam int LLAG = 64, LLEN = 64, SLAG = 16, SLEN = 16, DLAG = 16;
  localparam int MAXN = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 1'b0, smp_clip = 1'b0, rearm = 1'b0;
  logic signed [7:0] smp_re = '0, smp_im = '0;
  logic [7:0] hold_len = 8'd20;
  logic [45:0] det_floor = 46'd0;
  logic frame_det;
  logic signed [22:0] fine_re, fine_im;
  logic signed [20:0] coarse_re, coarse_im;

  always #5 clk = ~clk;

  plateau_frame_detector u_plateau_frame_detector (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_re(smp_re), .smp_im(smp_im),
    .smp_clip(smp_clip), .rearm(rearm), .hold_len(hold_len), .det_floor(det_floor),
    .frame_det(frame_det), .fine_re(fine_re), .fine_im(fine_im),
    .coarse_re(coarse_re), .coarse_im(coarse_im));

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model state
  longint xr [MAXN];
  longint xi [MAXN];
  longint jfr [MAXN];
  longint jfi [MAXN];
  longint qv [MAXN];
  longint dv [MAXN];
  int     n_smp = 0;
  longint m_max = 0;
  int     m_cnt = 0;
  bit     m_armed = 1'b1;
  bit     e_det = 1'b0;
  longint e_fr = 0, e_fi = 0, e_cr = 0, e_ci = 0;
  int     hw_det = 0, md_det = 0;
  int     lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void corr(input int k, input int lag, input int len,
                               output longint sr, output longint si);
    sr = 0; si = 0;
    for (int m = k - len + 1; m <= k; m++) begin
      if (m - lag >= 0) begin
        sr += xr[m] * xr[m-lag] + xi[m] * xi[m-lag];
        si += xi[m] * xr[m-lag] - xr[m] * xi[m-lag];
      end
    end
  endfunction

  function automatic longint qat(input int k);
    return (k >= 0) ? qv[k] : 0;
  endfunction

  function automatic int noise_val();
    lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
    return (lfsr % 17) - 8;
  endfunction

  task automatic step(input bit v, input int re, input int im, input bit clip,
                      input bit ra, input string req);
    longint dprev, a, b;
    @(negedge clk);
    smp_vld = v; smp_re = re[7:0]; smp_im = im[7:0]; smp_clip = clip; rearm = ra;
    @(posedge clk);
    #1;
    e_det = 1'b0;
    if (v) begin
      int k = n_smp;
      xr[k] = clip ? 0 : longint'(re);
      xi[k] = clip ? 0 : longint'(im);
      corr(k, LLAG, LLEN, a, b);
      jfr[k] = a; jfi[k] = b;
      qv[k] = (k >= 1) ? (jfr[k-1] * jfr[k-1] + jfi[k-1] * jfi[k-1]) : 0;
      dv[k] = qat(k - 1) - qat(k - 1 - DLAG);
      dprev = (k >= 1) ? dv[k-1] : 0;
      if (ra) begin
        m_max = 0; m_cnt = 0; m_armed = 1'b1;
      end else if (m_armed) begin
        if (dprev > m_max) begin
          m_max = dprev; m_cnt = 0;
        end else if (m_cnt < int'(hold_len)) begin
          m_cnt++;
          if (m_cnt == int'(hold_len) && m_max > longint'(det_floor)) begin
            e_det = 1'b1; m_armed = 1'b0;
          end
        end
      end
      if (e_det) begin
        e_fr = jfr[k]; e_fi = jfi[k];
        corr(k, SLAG, SLEN, a, b);
        e_cr = a; e_ci = b;
      end
      n_smp++;
    end else if (ra) begin
      m_max = 0; m_cnt = 0; m_armed = 1'b1;
    end
    if (e_det) md_det++;
    if (frame_det) hw_det++;
    chk(frame_det == e_det, req, "frame_det", longint'(frame_det), longint'(e_det));
    chk(longint'(fine_re) == e_fr, "R8", "fine_re", longint'(fine_re), e_fr);
    chk(longint'(fine_im) == e_fi, "R8", "fine_im", longint'(fine_im), e_fi);
    chk(longint'(coarse_re) == e_cr, "R8", "coarse_re", longint'(coarse_re), e_cr);
    chk(longint'(coarse_im) == e_ci, "R8", "coarse_im", longint'(coarse_im), e_ci);
  endtask

  function automatic int pat_re(input int i, input int amp);
    return ((i % 16) < 8) ? amp : -amp;
  endfunction
  function automatic int pat_im(input int i, input int amp);
    return (((i + 4) % 16) < 8) ? amp : -amp;
  endfunction

  task automatic noise(input int len, input string req);
    for (int i = 0; i < len; i++) step(1'b1, noise_val(), noise_val(), 1'b0, 1'b0, req);
  endtask

  task automatic burst(input int len, input int amp, input int clip_every,
                       input int gap_every, input string req);
    for (int i = 0; i < len; i++) begin
      if (gap_every > 0 && (i % gap_every) == gap_every - 1)
        step(1'b0, 99, -77, 1'b0, 1'b0, req);
      if (clip_every > 0 && (i % clip_every) == 0)
        step(1'b1, 127, -128, 1'b1, 1'b0, req);
      else
        step(1'b1, pat_re(i, amp), pat_im(i, amp), 1'b0, 1'b0, req);
    end
  endtask

  task automatic t_reset();
    chk(frame_det == 1'b0, "R11", "frame_det after reset", longint'(frame_det), 0);
    chk(fine_re == 0 && fine_im == 0, "R11", "fine after reset", longint'(fine_re), 0);
    chk(coarse_re == 0 && coarse_im == 0, "R11", "coarse after reset", longint'(coarse_re), 0);
  endtask

  // R2 R4 R5 R6 R7 R8: strong preamble after noise
  task automatic t_frame();
    int d0 = hw_det;
    hold_len = 8'd20; det_floor = 46'd1 << 30;
    noise(120, "R5");
    burst(260, 50, 0, 0, "R6");
    noise(60, "R7");
    chk(hw_det - d0 >= 1, "R6", "preamble detected", longint'(hw_det - d0), 1);
    chk(hw_det == md_det, "R2", "detect count", longint'(hw_det), longint'(md_det));
  endtask

  // R9: a second preamble without rearm stays silent
  task automatic t_ignore();
    int d0 = hw_det;
    burst(260, 50, 0, 0, "R9");
    noise(40, "R9");
    chk(hw_det == d0, "R9", "pulses while disarmed", longint'(hw_det - d0), 0);
  endtask

  // R6: floor above any reachable peak blocks detection
  task automatic t_floor();
    int d0 = hw_det;
    det_floor = 46'd1 << 40;
    step(1'b0, 0, 0, 1'b0, 1'b1, "R10");
    noise(40, "R6");
    burst(260, 50, 0, 0, "R6");
    chk(hw_det == d0, "R6", "pulses under high floor", longint'(hw_det - d0), 0);
  endtask

  // R1: saturated samples inside the burst enter as zero
  task automatic t_clip();
    det_floor = 46'd1 << 30;
    step(1'b0, 0, 0, 1'b0, 1'b1, "R10");
    noise(40, "R1");
    burst(260, 50, 7, 0, "R1");
    noise(20, "R1");
  endtask

  // R3: idle cycles inside the burst
  task automatic t_gaps();
    step(1'b0, 0, 0, 1'b0, 1'b1, "R10");
    noise(40, "R3");
    burst(260, 50, 0, 3, "R3");
    noise(20, "R3");
  endtask

  // R10: rearm coinciding with a sample, then a weak preamble must fire
  task automatic t_rearm();
    int d0 = hw_det;
    det_floor = 46'd1 << 24;
    step(1'b1, noise_val(), noise_val(), 1'b0, 1'b1, "R10");
    noise(40, "R10");
    burst(260, 20, 0, 0, "R10");
    noise(20, "R10");
    chk(hw_det - d0 >= 1, "R10", "weak preamble after rearm", longint'(hw_det - d0), 1);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_frame();
    t_ignore();
    t_floor();
    t_clip();
    t_gaps();
    t_rearm();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule